// File: doc/BRIEF.md
# Bit-Serial Two-Wire Bus Interface with Clock Stretching

This block connects a host processor to an I2C bus one bit at a time. On every rising edge of the clock line it latches the level of the data line into a receive bit. Unless the device is an idle slave, the same edge raises a data-ready flag. While data-ready stays set, the block holds the clock line low through the low phase that follows. The host reads the bit, writes the next outgoing bit and clears data-ready, and only then is the clock line let go. Software does all byte assembly, addressing and acknowledgement.

The block also watches the bus for start and stop conditions and for lost arbitration. Each of these sets a sticky flag. An attention flag is the OR of the four flags (data-ready, arbitration-lost, start-seen, stop-seen) and can drive an interrupt. Both bus lines are open drain: the block only asserts pull-low enables. The host reaches the block through a small register port with a status/control register (address 0), a data register (address 1) and a configuration register (address 2).

The handshake state machine has three states. HS_RUN means no bit is pending. HS_READY_HIGH means data-ready is set while the clock line is still high. HS_STRETCH means data-ready is set and the block is holding the clock line low. Its transitions are:
- RUN_TO_READY: a rising clock edge, when the device is not an idle slave.
- READY_TO_STRETCH: a falling clock edge.
- READY_TO_RUN and STRETCH_TO_RUN: a clear of data-ready.

Top module: `i2cb_top`

## Requirements
- R1: On each rising edge of the synchronized clock line, the synchronized data-line level is stored as the receive bit. The receive bit reads as bit 7 of the status register, and is 0 after reset.
- R2: A rising clock edge sets data-ready (status bit 5), except when master mode (configuration bit 0) is 0 and no frame is open. A frame is open from a start until the next stop, and status bit 1 shows it.
- R3: Data-ready is cleared by a status-register write with bit 0 = 1, by any write of the data register, or by any read of the data register.
- R4: After data-ready is set, the first falling clock edge makes the block assert the clock pull-down (scl_oe_o = 1). The block keeps it asserted until data-ready is cleared, and releases it on the clock edge at which data-ready clears. The pull-down is never asserted while data-ready is 0.
- R5: A start is the data line falling while the clock line is high. It sets start-seen (status bit 3) and opens a frame. A stop is the data line rising while the clock line is high. It sets stop-seen (status bit 2) and closes the frame.
- R6: In master mode, arbitration-lost (status bit 4) is set when, at a rising clock edge, the block is releasing the data line but samples it low.
- R7: Arbitration-lost, start-seen and stop-seen each stay set until the host writes a 1 to its own clear bit in the status register (bit 1, bit 2 and bit 3 respectively). Writing one clear bit leaves the other flags unchanged.
- R8: Status bit 6 (attention) is the OR of data-ready, arbitration-lost, start-seen and stop-seen. Status bit 0 reads 0.
- R9: A data-register read returns the receive bit in bit 7 and zeros in bits 6..0. A status-register read leaves data-ready unchanged.
- R10: irq_o is 1 exactly when attention is 1, the interface interrupt enable (configuration bit 1) is 1, and the global enable (configuration bit 2) is 1.
- R11: Bit 7 of a data-register write is the outgoing bit. sda_oe_o = 1 while that bit is 0. The outgoing bit is 1 after reset, and all flags and configuration bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line level as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| reg_addr_i | input | 2 | Register select: 0 status/control, 1 data, 2 configuration |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle (side effects only) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the data line does not change in the same system cycle as a clock-line edge at the synchronizer input. Under that assumption, an edge on the clock line is never also read as a start or stop. They also assume that register strobes last one cycle. The bench changes the data line only while it holds the clock line low, or on purpose while the clock line is high to make a start or stop. Between line changes it waits several system cycles, so the synchronizer always settles. The random outgoing bits and the random choice of clear method all fall inside the same legal bit sequence.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [1:0] {
        HS_RUN        = 2'd0,
        HS_READY_HIGH = 2'd1,
        HS_STRETCH    = 2'd2
    } hs_state_t;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_DATA = 2'd1,
        REG_CFG  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_t;

    // status read bit positions
    localparam int ST_RDAT  = 7;
    localparam int ST_ATTN  = 6;
    localparam int ST_DRDY  = 5;
    localparam int ST_ARBL  = 4;
    localparam int ST_START = 3;
    localparam int ST_STOP  = 2;
    localparam int ST_FRAME = 1;

    // status write (clear) bit positions
    localparam int CL_DRDY  = 0;
    localparam int CL_ARBL  = 1;
    localparam int CL_START = 2;
    localparam int CL_STOP  = 3;

    // configuration bit positions
    localparam int CF_MASTER = 0;
    localparam int CF_IE     = 1;
    localparam int CF_GIE    = 2;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/i2cb_cond_det.sv
module i2cb_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s_i;
            sda_q <= sda_s_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_s_i & ~scl_q;
        scl_fall_o = ~scl_s_i & scl_q;
        start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
        stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
    end

endmodule

// File: rtl/i2cb_handshake_fsm.sv
module i2cb_handshake_fsm
    import i2cb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    input  logic arm_ok_i,
    input  logic clr_i,
    output logic drdy_o,
    output logic scl_hold_o
);

    hs_state_t state_q;
    hs_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_RUN: begin
                if (scl_rise_i && arm_ok_i) state_d = HS_READY_HIGH;  // RUN_TO_READY
            end
            HS_READY_HIGH: begin
                if (clr_i)           state_d = HS_RUN;                // READY_TO_RUN
                else if (scl_fall_i) state_d = HS_STRETCH;            // READY_TO_STRETCH
            end
            HS_STRETCH: begin
                if (clr_i) state_d = HS_RUN;                          // STRETCH_TO_RUN
            end
            default: state_d = HS_RUN;
        endcase
    end

    // outputs
    always_comb begin
        drdy_o     = 1'b0;
        scl_hold_o = 1'b0;
        unique case (state_q)
            HS_RUN:        ;
            HS_READY_HIGH: drdy_o = 1'b1;
            HS_STRETCH: begin
                drdy_o     = 1'b1;
                scl_hold_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: the hold is let go on the edge that clears data-ready
    p_release_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_o && clr_i) |=> !scl_hold_o);

    // R4: the hold only starts after a falling clock edge
    p_hold_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> $past(scl_fall_i));

endmodule

// File: rtl/i2cb_top.sv
module i2cb_top
    import i2cb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_o
);

    localparam int MSB = REG_W - 1;

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       drdy, drdy_clr;
    logic       rdat_q, tx_q, in_frame_q;
    logic       arbl_q, start_q, stop_q;
    logic       master_q, ie_q, gie_q;
    logic       attn, arb_hit;
    logic       wr_stat, wr_data, rd_data, wr_cfg;
    reg_sel_t   sel;

    i2cb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cb_cond_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    // register decode
    always_comb begin
        sel     = reg_sel_t'(reg_addr_i);
        wr_stat = reg_wr_i && (sel == REG_STAT);
        wr_data = reg_wr_i && (sel == REG_DATA);
        rd_data = reg_rd_i && (sel == REG_DATA);
        wr_cfg  = reg_wr_i && (sel == REG_CFG);
    end

    assign drdy_clr = (wr_stat && reg_wdata_i[CL_DRDY]) || wr_data || rd_data;

    i2cb_handshake_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .arm_ok_i   (master_q || in_frame_q),
        .clr_i      (drdy_clr),
        .drdy_o     (drdy),
        .scl_hold_o (scl_oe_o)
    );

    assign arb_hit = master_q && tx_q && scl_rise && !sda_s;

    // bit path and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q     <= 1'b0;
            tx_q       <= 1'b1;
            in_frame_q <= 1'b0;
            master_q   <= 1'b0;
            ie_q       <= 1'b0;
            gie_q      <= 1'b0;
        end else begin
            if (scl_rise) rdat_q <= sda_s;
            if (wr_data)  tx_q   <= reg_wdata_i[MSB];
            if (start_det)     in_frame_q <= 1'b1;
            else if (stop_det) in_frame_q <= 1'b0;
            if (wr_cfg) begin
                master_q <= reg_wdata_i[CF_MASTER];
                ie_q     <= reg_wdata_i[CF_IE];
                gie_q    <= reg_wdata_i[CF_GIE];
            end
        end
    end

    // sticky event flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arbl_q  <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            if (arb_hit)                                arbl_q <= 1'b1;
            else if (wr_stat && reg_wdata_i[CL_ARBL])   arbl_q <= 1'b0;
            if (start_det)                              start_q <= 1'b1;
            else if (wr_stat && reg_wdata_i[CL_START])  start_q <= 1'b0;
            if (stop_det)                               stop_q <= 1'b1;
            else if (wr_stat && reg_wdata_i[CL_STOP])   stop_q <= 1'b0;
        end
    end

    assign attn     = drdy | arbl_q | start_q | stop_q;
    assign irq_o    = attn & ie_q & gie_q;
    assign sda_oe_o = ~tx_q;

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            REG_STAT: begin
                reg_rdata_o[ST_RDAT]  = rdat_q;
                reg_rdata_o[ST_ATTN]  = attn;
                reg_rdata_o[ST_DRDY]  = drdy;
                reg_rdata_o[ST_ARBL]  = arbl_q;
                reg_rdata_o[ST_START] = start_q;
                reg_rdata_o[ST_STOP]  = stop_q;
                reg_rdata_o[ST_FRAME] = in_frame_q;
            end
            REG_DATA: reg_rdata_o[MSB] = rdat_q;
            REG_CFG: begin
                reg_rdata_o[CF_MASTER] = master_q;
                reg_rdata_o[CF_IE]     = ie_q;
                reg_rdata_o[CF_GIE]    = gie_q;
            end
            REG_NONE: ;
            default: ;
        endcase
    end

    // R1: receive bit follows the data line sampled at the rising clock edge
    p_rdat_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> (rdat_q == $past(sda_s)));

    // R2: an idle slave never raises data-ready
    p_idle_slave_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && !master_q && !in_frame_q && !drdy) |=> !drdy);

    // R3: any data register access clears data-ready
    p_data_access_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr_i || reg_rd_i) && sel == REG_DATA && !scl_rise) |=> !drdy);

    // R5: a start opens a frame and is flagged
    p_start_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (start_q && in_frame_q));

    // R6: released line sampled low in master mode flags arbitration loss
    p_arb_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && master_q && !sda_oe_o && !sda_s) |=> arbl_q);

    // R7: arbitration-lost holds until its own clear bit is written
    p_arbl_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arbl_q && !(wr_stat && reg_wdata_i[CL_ARBL])) |=> arbl_q);

    // R10: a new attention with both enables set raises the request
    p_irq_on_attn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(attn) && ie_q && gie_q) |-> irq_o);

endmodule

// File: tb/tb_i2cb_top.sv
module tb_i2cb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_scl_lo = 1'b0;
    logic       tb_sda_lo = 1'b0;
    logic       scl_oe, sda_oe, irq;
    logic       scl_bus, sda_bus;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign scl_bus = !(scl_oe | tb_scl_lo);
    assign sda_bus = !(sda_oe | tb_sda_lo);

    i2cb_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_bus),
        .sda_i       (sda_bus),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // expected status byte, built from the bit positions in the requirements
    function automatic logic [7:0] exp_stat(input logic rdat, input logic drdy,
                                            input logic arbl, input logic st,
                                            input logic sp, input logic frame);
        logic [7:0] v;
        v    = 8'h00;
        v[7] = rdat;
        v[6] = drdy | arbl | st | sp;
        v[5] = drdy;
        v[4] = arbl;
        v[3] = st;
        v[2] = sp;
        v[1] = frame;
        return v;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic       m_rdat;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);

        // reset state (R11)
        reg_rd(2'd0, v); check("R11 reset status", v, 8'h00);
        reg_rd(2'd2, v); check("R11 reset config", v, 8'h00);
        check("R11 reset pins", {5'd0, scl_oe, sda_oe, irq}, 8'h00);

        // idle slave: bits captured, no data-ready (R1, R2)
        for (int i = 0; i < 4; i++) begin
            logic b;
            b = 1'($urandom % 2);
            tb_scl_lo = 1'b1; wait_cyc(4);
            tb_sda_lo = !b;   wait_cyc(4);
            tb_scl_lo = 1'b0; wait_cyc(5);
            reg_rd(2'd0, v); check("R1 R2 idle slave capture", v, exp_stat(b, 0, 0, 0, 0, 0));
        end
        tb_scl_lo = 1'b1; wait_cyc(4);
        tb_sda_lo = 1'b0; wait_cyc(4);
        tb_scl_lo = 1'b0; wait_cyc(5);
        m_rdat = 1'b1;

        // start condition (R5, R8, R10)
        tb_sda_lo = 1'b1; wait_cyc(5);
        reg_rd(2'd0, v); check("R5 R8 start seen", v, exp_stat(m_rdat, 0, 0, 1, 0, 1));
        check("R10 irq disabled", {7'd0, irq}, 8'h00);
        reg_wr(2'd2, 8'h06);
        check("R10 irq both enables", {7'd0, irq}, 8'h01);
        reg_wr(2'd2, 8'h02);
        check("R10 irq global off", {7'd0, irq}, 8'h00);
        reg_wr(2'd2, 8'h06);
        reg_rd(2'd2, v); check("R10 config readback", v, 8'h06);
        reg_wr(2'd0, 8'h04);
        reg_rd(2'd0, v); check("R7 clear start", v, exp_stat(m_rdat, 0, 0, 0, 0, 1));
        check("R10 irq after clear", {7'd0, irq}, 8'h00);
        tb_scl_lo = 1'b1; wait_cyc(4);

        // random bits in a frame with stretching and random clear method
        for (int i = 0; i < 40; i++) begin
            logic b;
            int   how;
            b   = 1'($urandom % 2);
            how = int'($urandom % 3);
            tb_sda_lo = !b;   wait_cyc(4);
            tb_scl_lo = 1'b0; wait_cyc(5);
            reg_rd(2'd0, v); check("R1 R2 R9 bit ready", v, exp_stat(b, 1, 0, 0, 0, 1));
            check("R10 irq on ready", {7'd0, irq}, 8'h01);
            tb_scl_lo = 1'b1; wait_cyc(6);
            tb_scl_lo = 1'b0; wait_cyc(3);
            check("R4 stretch holds clock", {6'd0, scl_oe, scl_bus}, 8'h02);
            tb_scl_lo = 1'b1; wait_cyc(2);
            if (how == 0) begin
                reg_wr(2'd0, 8'h01);
            end else if (how == 1) begin
                reg_rd(2'd1, v); check("R9 data read value", v, {b, 7'd0});
            end else begin
                reg_wr(2'd1, 8'h80);
            end
            check("R3 R4 clear releases", {7'd0, scl_oe}, 8'h00);
            reg_rd(2'd0, v); check("R3 ready cleared", v, exp_stat(b, 0, 0, 0, 0, 1));
            check("R11 data line released", {7'd0, sda_oe}, 8'h00);
        end

        // stop condition (R5, R7)
        tb_sda_lo = 1'b1; wait_cyc(4);
        tb_scl_lo = 1'b0; wait_cyc(5);
        reg_wr(2'd0, 8'h01);
        tb_sda_lo = 1'b0; wait_cyc(5);
        reg_rd(2'd0, v); check("R5 stop seen", v, exp_stat(0, 0, 0, 0, 1, 0));
        reg_wr(2'd0, 8'h08);
        reg_rd(2'd0, v); check("R7 clear stop", v, exp_stat(0, 0, 0, 0, 0, 0));

        // master mode: idle ready and arbitration loss (R2, R6, R7)
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd1, 8'h80);
        tb_scl_lo = 1'b1; wait_cyc(4);
        tb_sda_lo = 1'b1; wait_cyc(4);
        tb_scl_lo = 1'b0; wait_cyc(5);
        reg_rd(2'd0, v); check("R2 R6 master arb lost", v, exp_stat(0, 1, 1, 0, 0, 0));
        check("R10 irq masked", {7'd0, irq}, 8'h00);
        reg_wr(2'd0, 8'h02);
        reg_rd(2'd0, v); check("R7 clear arb only", v, exp_stat(0, 1, 0, 0, 0, 0));
        reg_wr(2'd0, 8'h01);
        reg_rd(2'd0, v); check("R3 ctrl clear ready", v, exp_stat(0, 0, 0, 0, 0, 0));

        // outgoing bit drives the data line (R11)
        reg_wr(2'd1, 8'h00);
        check("R11 drive low", {7'd0, sda_oe}, 8'h01);
        reg_wr(2'd1, 8'h80);
        check("R11 release", {7'd0, sda_oe}, 8'h00);
        tb_sda_lo = 1'b0; wait_cyc(5);
        reg_rd(2'd0, v); check("R5 R8 stop in master", v, exp_stat(0, 0, 0, 0, 1, 0));
        reg_wr(2'd0, 8'h08);
        reg_rd(2'd0, v); check("R7 final clear", v, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule